// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits next to a single-port data memory shared by several hardware threads and decides whether each store-conditional may reach the memory. Every cycle at most one thread presents a request, which carries a thread number, an operation code, a byte address and write data. The monitor passes the address and data through to the memory and drives the memory write enable. It does not hold data. A load-linked reads memory as a normal load does, and it also records a reservation for the issuing thread.

Each thread has one reservation register. The register holds a valid flag and the number of the aligned address block that contains the load-linked address. The block is 64 bytes by default. Every write that reaches the memory is compared against the trackers of all other threads, and a block match clears those reservations. A store-conditional is granted only if its own thread still holds a reservation for the block it targets. The grant or refusal is reported in the same cycle as the request.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no thread holds a reservation, so a store-conditional from any thread fails (`sc_fail`=1) and does not write (`mem_we`=0). An asserted reset also discards reservations taken before it.
- R2: The operation code is 0 for load, 1 for store, 2 for load-linked and 3 for store-conditional. A load-linked creates a reservation for its thread. A later store-conditional from that thread to the same block succeeds: `sc_done`=1, `sc_fail`=0 and `mem_we`=1, all in the request cycle.
- R3: A store-conditional that fails does not assert `mem_we`.
- R4: A write that reaches memory from a different thread, to the reserved block, clears the reservation. The next store-conditional from the reserving thread then fails.
- R5: A write from another thread to a different block leaves the reservation intact.
- R6: A store-conditional clears its own thread's reservation, whether it succeeds or fails.
- R7: A new load-linked replaces the thread's previous reservation with the new block.
- R8: A store-conditional to a block other than the reserved one fails.
- R9: A thread's own ordinary store to its reserved block leaves its reservation intact.
- R10: A failed store-conditional from another thread writes nothing and so breaks no reservation.
- R11: Ordinary stores always assert `mem_we`. Loads, load-linked requests and idle cycles never assert it. `sc_done` is 1 only for a store-conditional request, and `sc_fail` is 0 whenever `sc_done` is 0.
- R12: A reservation covers the whole aligned block, which spans address bits [ADDR_W-1:BLK_LSB]. A store-conditional to any byte of that block is treated as a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_tid | input | TID_W | Issuing thread number |
| req_op | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Address to memory |
| mem_wdata | output | DATA_W | Write data to memory |
| sc_done | output | 1 | A store-conditional is resolved this cycle |
| sc_fail | output | 1 | 0 means granted, 1 means refused |

## Verification
A wrong tracker shows up at the ports only when the owning thread next issues a store-conditional. At that point it appears either as a write that should have been refused, or as a refusal of a write that should have been granted. The stimulus therefore ends every reservation scenario with a store-conditional placed right after the event under test. The event may be a foreign write, an own write, a replacing load-linked, a failed conditional store or a reset. Placing the check there makes a stale or wrongly cleared flag visible within one or two cycles. The block comparison is probed with addresses that differ only inside the block and with addresses that differ just above it.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int THREADS = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int BLK_LSB = 6,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int BLK_W  = ADDR_W - BLK_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sc_done,
  output logic              sc_fail
);
  localparam logic [1:0] OP_ST = 2'd1, OP_LL = 2'd2, OP_SC = 2'd3;

  logic [THREADS-1:0] rsv_vld;
  logic [BLK_W-1:0]   rsv_blk [THREADS];
  logic [THREADS-1:0] hit_vec;
  logic [BLK_W-1:0]   req_blk;

  assign req_blk   = req_addr[ADDR_W-1:BLK_LSB];
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;
  assign sc_done   = req_valid && (req_op == OP_SC);
  assign sc_fail   = sc_done && !hit_vec[req_tid];
  assign mem_we    = req_valid && ((req_op == OP_ST) || (sc_done && !sc_fail));

  for (genvar t = 0; t < THREADS; t++) begin : g_trk
    logic own;
    assign own        = req_valid && (req_tid == TID_W'(t));
    assign hit_vec[t] = rsv_vld[t] && (rsv_blk[t] == req_blk);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsv_vld[t] <= 1'b0;
        rsv_blk[t] <= '0;
      end else if (own && req_op == OP_LL) begin
        rsv_vld[t] <= 1'b1;
        rsv_blk[t] <= req_blk;
      end else if (own && req_op == OP_SC) begin
        rsv_vld[t] <= 1'b0;
      end else if (mem_we && !own && hit_vec[t]) begin
        rsv_vld[t] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int TID_W   = 2,
  parameter int ADDR_W  = 12,
  parameter int BLK_LSB = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [TID_W-1:0]  req_tid,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_we,
  input logic              sc_done,
  input logic              sc_fail
);
  logic [ADDR_W-BLK_LSB-1:0] blk;
  logic is_sc;
  assign blk   = req_addr[ADDR_W-1:BLK_LSB];
  assign is_sc = req_valid && req_op == 2'd3;

  a_r3_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && sc_fail) |-> !mem_we);

  a_r2_grant_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && !sc_fail) |-> mem_we);

  a_r11_store_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1) |-> (mem_we && !sc_done && !sc_fail));

  a_r11_no_write_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_op == 2'd0 || req_op == 2'd2) |-> (!mem_we && !sc_done && !sc_fail));

  a_r6_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |=> ((is_sc && req_tid == $past(req_tid)) -> sc_fail));

  a_r4_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ((is_sc && req_tid != $past(req_tid) && blk == $past(blk)) -> sc_fail));
endmodule

bind llsc_monitor llsc_monitor_chk #(.TID_W(TID_W), .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
  .req_op(req_op), .req_addr(req_addr), .mem_we(mem_we),
  .sc_done(sc_done), .sc_fail(sc_fail)
);

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_tid = '0;
  logic [1:0]  req_op = '0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_we, sc_done, sc_fail;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  llsc_monitor u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sc_done(sc_done), .sc_fail(sc_fail)
  );

  // {tid, op, addr, we, done, fail}; op 0 LD 1 ST 2 LL 3 SC
  localparam int NV = 23;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 2'd3, 12'h040, 3'b011},  // R1 no reservation
    {2'd0, 2'd2, 12'h040, 3'b000},
    {2'd0, 2'd3, 12'h07C, 3'b110},  // R2 R12 same block
    {2'd0, 2'd3, 12'h040, 3'b011},  // R6 cleared by success
    {2'd1, 2'd2, 12'h100, 3'b000},
    {2'd2, 2'd1, 12'h13C, 3'b100},  // R4 foreign store
    {2'd1, 2'd3, 12'h100, 3'b011},  // R4 R3
    {2'd1, 2'd2, 12'h100, 3'b000},
    {2'd2, 2'd1, 12'h140, 3'b100},  // R5 adjacent block
    {2'd1, 2'd1, 12'h104, 3'b100},  // R9 own store
    {2'd1, 2'd3, 12'h100, 3'b110},  // R5 R9
    {2'd3, 2'd2, 12'h300, 3'b000},
    {2'd3, 2'd2, 12'h400, 3'b000},  // R7 replace
    {2'd3, 2'd3, 12'h300, 3'b011},  // R8 other block
    {2'd3, 2'd3, 12'h400, 3'b011},  // R6 cleared by failure
    {2'd0, 2'd2, 12'h500, 3'b000},
    {2'd1, 2'd3, 12'h500, 3'b011},  // R10 foreign failed SC
    {2'd0, 2'd3, 12'h500, 3'b110},  // R10
    {2'd2, 2'd0, 12'h500, 3'b000},  // R11 load
    {2'd0, 2'd2, 12'h600, 3'b000},
    {2'd1, 2'd2, 12'h600, 3'b000},
    {2'd0, 2'd3, 12'h600, 3'b110},
    {2'd1, 2'd3, 12'h600, 3'b011}   // R4 foreign SC write
  };

  task automatic check(string req, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {we,done,fail} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic issue(logic v, logic [1:0] t, logic [1:0] op, logic [11:0] a);
    @(negedge clk);
    req_valid = v; req_tid = t; req_op = op; req_addr = a;
    req_wdata = {20'h0, a} ^ 32'hA5A5_0000;
    #2;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset idle", {mem_we, sc_done, sc_fail}, 3'b000);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VEC[i][18:17], VEC[i][16:15], VEC[i][14:3]);
      check($sformatf("vector %0d", i), {mem_we, sc_done, sc_fail}, VEC[i][2:0]);
      if (mem_addr !== req_addr || mem_wdata !== req_wdata) begin
        checks++; fails++;
        $display("FAIL R11 passthrough: got %h expected %h", mem_addr, req_addr);
      end
    end
    // R11 idle cycle carrying store-like fields
    issue(1'b0, 2'd0, 2'd1, 12'h040);
    check("R11 idle", {mem_we, sc_done, sc_fail}, 3'b000);
    // R1 reset discards reservations
    issue(1'b1, 2'd2, 2'd2, 12'h700);
    issue(1'b0, 2'd0, 2'd0, 12'h000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    issue(1'b1, 2'd2, 2'd3, 12'h700);
    check("R1 reset clears", {mem_we, sc_done, sc_fail}, 3'b011);
    // R12 block boundary: last byte of block vs first byte above
    issue(1'b1, 2'd1, 2'd2, 12'h7C0);
    issue(1'b1, 2'd1, 2'd3, 12'h800);
    check("R12 R8 above block", {mem_we, sc_done, sc_fail}, 3'b011);
    issue(1'b1, 2'd1, 2'd2, 12'h7C0);
    issue(1'b1, 2'd1, 2'd3, 12'h7FF);
    check("R12 last byte", {mem_we, sc_done, sc_fail}, 3'b110);
    issue(1'b0, 2'd0, 2'd0, 12'h000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule